// File: doc/BRIEF.md
# Synchronous burst read controller

This block is the read-side sequencer of a memory array that serves both plain asynchronous reads and clocked burst reads. A 16-bit configuration word, written through a command port, chooses the read mode, the first-data latency, how long each output word is held, the burst length, wrap and ordering, and the level and timing of a WAIT output. The block latches a start address on an active-low address-latch strobe, produces the word addresses presented to the array, registers the returned words onto its data output, and tells the host through WAIT when the data stream stalls.

In burst mode the first word appears a programmable number of clocks after the latch edge. Later words follow at one word per clock, or one word per two clocks. Wrapped bursts of 4 or 8 words stay inside their aligned group, in sequential or interleaved order. Linear bursts (4 or 8 words with no wrap, or continuous) walk upward through the array. Each time a linear burst moves into a new 16-word row it stalls for one clock, and WAIT marks that clock.

Top module: `burst_read_ctrl`

## Requirements
- R1: After reset the live configuration holds asynchronous mode, latency 3, WAIT active high, one-cycle hold, early WAIT, sequential order, no-wrap and continuous length. waitOut is 0 and dataOut shows the word at address 0.
- R2: With bit 15 = 1 (asynchronous), memAddr is addrIn while advN is low and is the last latched address otherwise. dataOut follows memData in the same cycle, no burst starts and waitOut stays inactive.
- R3: A write through cfgWe goes first to a staging copy. That copy becomes live at the first clock edge where no burst is running and advN is high. A write made during a burst leaves the rest of that burst unchanged.
- R4: Bits 13:11 set the latency L, and the first burst word is on dataOut in the L-th cycle after the latch edge. Codes 2 to 6 are used as written, codes 0 and 1 act as 2, and code 7 acts as 6.
- R5: Bit 9 = 0 holds each burst word on dataOut for one cycle, and bit 9 = 1 holds it for two cycles.
- R6: Bits 2:0 set the length (001 = 4 words, 010 = 8 words, 111 = continuous, any other value = single word). With bit 7 = 1 (sequential) and bit 3 = 0 (wrap), beat i reads offset (start + i) mod N inside the aligned N-word group.
- R7: With bit 7 = 0 (interleaved), a 4- or 8-word burst reads offset (start XOR i) inside the aligned group, whatever bit 3 holds.
- R8: A continuous burst, or a sequential 4/8-word burst with bit 3 = 1 (no wrap), reads start + i. A fixed-length burst stops after N words and leaves the last one on dataOut. A continuous burst runs until the next latch or reset.
- R9: When a linear burst's next word lies at an address whose low four bits are 0, one extra cycle is inserted before that word, and dataOut keeps the previous word during it.
- R10: With bit 8 = 0, WAIT is active during the inserted cycle. With bit 8 = 1, it is active in the cycle before it.
- R11: Bit 10 gives WAIT's active level (1 = high, 0 = low). While oeN is high, waitOut is held at the inactive level.
- R12: WAIT stays inactive in asynchronous mode, during the latency period, in single-word bursts and in wrapped or interleaved bursts.
- R13: A falling latch (advN low at a clock edge) during a burst abandons it and starts a new burst from addrIn using the same configuration.
- R14: A configuration write with bit 14 set, bit 5 or bit 4 set, or bit 6 clear (this block clocks on the rising edge only) is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 16 | Configuration word |
| advN | input | 1 | Active-low address latch strobe |
| addrIn | input | AW | Start address |
| oeN | input | 1 | Active-low output enable |
| memAddr | output | AW | Word address to the array |
| memData | input | DW | Array read data for memAddr |
| dataOut | output | DW | Read data to the host |
| waitOut | output | 1 | WAIT indication |

## Verification
The hardest state to reach is a row-crossing stall inside a linear burst with a two-cycle hold and early WAIT. It only occurs when the start address sits a few words below a 16-word row boundary, and only after a configuration has been staged and then made live during an idle edge. The stimulus therefore writes each configuration, leaves an idle edge, and then latches start addresses such as 0x003D, 0x00FA and 0x01FE. A staged write is also issued in the middle of a long burst, so that the stalls before it still follow the old settings.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef struct packed {
    logic       asyncMode;
    logic [2:0] lat;
    logic       waitHigh;
    logic       hold2;
    logic       waitEarly;
    logic       seqOrder;
    logic       noWrap;
    logic [2:0] lenCode;
  } cfg_t;

  typedef struct packed {
    logic start;
    logic capture;
  } strobe_t;

  localparam logic [2:0] LEN_FOUR  = 3'b001;
  localparam logic [2:0] LEN_EIGHT = 3'b010;
  localparam logic [2:0] LEN_CONT  = 3'b111;
  localparam logic [2:0] LAT_MIN   = 3'd2;
  localparam logic [2:0] LAT_MAX   = 3'd6;

  localparam cfg_t CFG_RESET = '{asyncMode: 1'b1, lat: 3'd3, waitHigh: 1'b1,
                                 hold2: 1'b0, waitEarly: 1'b1, seqOrder: 1'b1,
                                 noWrap: 1'b1, lenCode: LEN_CONT};

  function automatic logic [2:0] legalLat(input logic [2:0] code);
    if (code < LAT_MIN)      return LAT_MIN;
    else if (code > LAT_MAX) return LAT_MAX;
    else                     return code;
  endfunction

endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [15:0] cfgData,
  input  logic        advN,
  input  logic        busy,
  output cfg_t        liveCfg
);

  cfg_t stagedCfg;
  logic writeOk;

  assign writeOk = cfgWe && cfgData[6] && !cfgData[14] && (cfgData[5:4] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedCfg <= CFG_RESET;
      liveCfg   <= CFG_RESET;
    end else begin
      if (writeOk) begin
        stagedCfg <= '{asyncMode: cfgData[15], lat: legalLat(cfgData[13:11]),
                       waitHigh: cfgData[10], hold2: cfgData[9],
                       waitEarly: cfgData[8], seqOrder: cfgData[7],
                       noWrap: cfgData[3], lenCode: cfgData[2:0]};
      end
      if (!busy && advN) liveCfg <= stagedCfg;
    end
  end

endmodule

// File: rtl/brc_datapath.sv
module brc_datapath
  import brc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advN,
  input  logic [AW-1:0] addrIn,
  input  logic          asyncMode,
  input  logic          seqOrder,
  input  logic          noWrap,
  input  logic [2:0]    lenCode,
  input  strobe_t       strb,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] dataOut,
  output logic          rowCross
);

  localparam int ROW_BITS = $clog2(ROW_WORDS);

  logic [AW-1:0] baseQ, beatIdx, beatAddr, lowMask;
  logic [DW-1:0] dataQ;
  logic          linear, fixedLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      beatIdx <= '0;
      dataQ   <= '0;
    end else begin
      if (!advN) baseQ <= addrIn;
      if (strb.start)        beatIdx <= '0;
      else if (strb.capture) beatIdx <= beatIdx + 1'b1;
      if (strb.capture) dataQ <= memData;
    end
  end

  always_comb begin
    fixedLen = (lenCode == LEN_FOUR) || (lenCode == LEN_EIGHT);
    lowMask  = (lenCode == LEN_EIGHT) ? AW'(7) : AW'(3);
    linear   = (lenCode == LEN_CONT) || (seqOrder && noWrap && fixedLen);
    if (linear)
      beatAddr = baseQ + beatIdx;
    else if (!seqOrder)
      beatAddr = (baseQ & ~lowMask) | ((baseQ ^ beatIdx) & lowMask);
    else
      beatAddr = (baseQ & ~lowMask) | ((baseQ + beatIdx) & lowMask);
  end

  assign rowCross = linear && (beatIdx != '0) && (beatAddr[ROW_BITS-1:0] == '0);
  assign memAddr  = asyncMode ? (advN ? baseQ : addrIn) : beatAddr;
  assign dataOut  = asyncMode ? memData : dataQ;

endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
  import brc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       advN,
  input  logic       oeN,
  input  logic       asyncMode,
  input  logic [2:0] lat,
  input  logic       waitHigh,
  input  logic       hold2,
  input  logic       waitEarly,
  input  logic [2:0] lenCode,
  input  logic       rowCross,
  output strobe_t    strb,
  output logic       busy,
  output logic       waitOut
);

  logic       inLat, holdCnt, skipDone, inWait;
  logic [2:0] latCnt;
  logic [3:0] beats, lenBeats;
  logic       cont, done, beatTime, skip, latDone, waitAssert;

  always_comb begin
    case (lenCode)
      LEN_FOUR:  lenBeats = 4'd4;
      LEN_EIGHT: lenBeats = 4'd8;
      default:   lenBeats = 4'd1;
    endcase
    cont         = (lenCode == LEN_CONT);
    done         = !cont && (beats == lenBeats);
    beatTime     = busy && !inLat && !holdCnt;
    skip         = beatTime && !done && rowCross && !skipDone;
    latDone      = busy && inLat && (latCnt == '0);
    strb.start   = !advN && !asyncMode;
    strb.capture = !strb.start && (latDone || (beatTime && !done && !skip));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; inLat <= 1'b0; latCnt <= '0; holdCnt <= 1'b0;
      beats <= '0; skipDone <= 1'b0; inWait <= 1'b0;
    end else if (strb.start) begin
      busy <= 1'b1; inLat <= 1'b1; latCnt <= lat - 3'd1;
      beats <= '0; skipDone <= 1'b0; inWait <= 1'b0; holdCnt <= 1'b0;
    end else if (busy && inLat) begin
      if (latDone) begin
        inLat <= 1'b0; beats <= 4'd1; holdCnt <= hold2;
      end else begin
        latCnt <= latCnt - 3'd1;
      end
    end else if (busy) begin
      inWait <= 1'b0;
      if (holdCnt) begin
        holdCnt <= 1'b0;
      end else if (done) begin
        busy <= 1'b0;
      end else if (skip) begin
        skipDone <= 1'b1; inWait <= 1'b1;
      end else begin
        beats <= beats + 4'd1; skipDone <= 1'b0; holdCnt <= hold2;
      end
    end
  end

  assign waitAssert = busy && (waitEarly ? skip : inWait);
  assign waitOut    = (!oeN && waitAssert) ? waitHigh : !waitHigh;

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import brc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [15:0]   cfgData,
  input  logic          advN,
  input  logic [AW-1:0] addrIn,
  input  logic          oeN,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memData,
  output logic [DW-1:0] dataOut,
  output logic          waitOut
);

  cfg_t    liveCfg;
  strobe_t strb;
  logic    busy, rowCross;

  brc_cfg_reg uCfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .advN(advN), .busy(busy), .liveCfg(liveCfg)
  );

  brc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .advN(advN), .oeN(oeN),
    .asyncMode(liveCfg.asyncMode), .lat(liveCfg.lat),
    .waitHigh(liveCfg.waitHigh), .hold2(liveCfg.hold2),
    .waitEarly(liveCfg.waitEarly), .lenCode(liveCfg.lenCode),
    .rowCross(rowCross), .strb(strb), .busy(busy), .waitOut(waitOut)
  );

  brc_datapath #(.AW(AW), .DW(DW), .ROW_WORDS(ROW_WORDS)) uData (
    .clk(clk), .rstN(rstN), .advN(advN), .addrIn(addrIn),
    .asyncMode(liveCfg.asyncMode), .seqOrder(liveCfg.seqOrder),
    .noWrap(liveCfg.noWrap), .lenCode(liveCfg.lenCode), .strb(strb),
    .memData(memData), .memAddr(memAddr), .dataOut(dataOut),
    .rowCross(rowCross)
  );

endmodule

// File: rtl/brc_checker.sv
module brc_checker
  import brc_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    oeN,
  input logic    waitOut,
  input strobe_t strb,
  input logic    busy,
  input cfg_t    cfg
);

  assert_hold_two_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && cfg.hold2) |=> !strb.capture);

  assert_lat_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> !strb.capture);

  assert_async_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfg.asyncMode |-> (!strb.capture && !busy));

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg));

  assert_wait_in_burst_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && (waitOut == cfg.waitHigh)) |-> busy);

endmodule

bind burst_read_ctrl brc_checker u_chk (
  .clk(clk), .rstN(rstN), .oeN(oeN), .waitOut(waitOut),
  .strb(strb), .busy(busy), .cfg(liveCfg)
);

// File: tb/sim_burst_read_ctrl.sv
`timescale 1ns/1ps
module sim_burst_read_ctrl;

  logic        clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, advN = 1'b1, oeN = 1'b0;
  logic [15:0] cfgData = '0, addrIn = '0, memAddr, memData, dataOut;
  logic        waitOut;

  always #10 clk = ~clk;

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return (a * 16'h03A7) ^ 16'h5C31;
  endfunction
  assign memData = memFn(memAddr);

  burst_read_ctrl u0 (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .advN(advN), .addrIn(addrIn), .oeN(oeN), .memAddr(memAddr),
    .memData(memData), .dataOut(dataOut), .waitOut(waitOut));

  int nChecks = 0, nErr = 0;
  string curTag = "R1";
  logic [15:0] mShadow, mLive, lastData, mBase, expD;
  logic [15:0] qData[$];
  bit          qWait[$];
  bit          expW;
  int          busyLeft;

  function automatic logic [15:0] mkCfg(bit am, int lat, bit pol, bit h2, bit early,
                                        bit seq, bit nw, logic [2:0] len);
    logic [15:0] w = 16'h0040;
    w[15] = am; w[13:11] = lat[2:0]; w[10] = pol; w[9] = h2; w[8] = early;
    w[7] = seq; w[3] = nw; w[2:0] = len;
    return w;
  endfunction

  function automatic int beatAddr(int base, int i, logic [15:0] w);
    int g = (w[2:0] == 3'b010) ? 8 : 4;
    bit cont = (w[2:0] == 3'b111);
    bit lin = cont || (w[7] && w[3] && (w[2:0] == 3'b001 || w[2:0] == 3'b010));
    int gb = base - (base % g);
    int off = base % g;
    if (lin) return (base + i) & 16'hFFFF;
    if (!w[7]) return gb + (off ^ i);
    return gb + ((off + i) % g);
  endfunction

  task automatic buildBurst(int base);
    int lat = mLive[13:11];
    int h = mLive[9] ? 2 : 1;
    int n;
    logic [15:0] dq[$];
    bit wf[$];
    logic [15:0] prev;
    bit cont = (mLive[2:0] == 3'b111);
    bit lin = cont || (mLive[7] && mLive[3] && (mLive[2:0] == 3'b001 || mLive[2:0] == 3'b010));
    if (lat < 2) lat = 2;
    if (lat > 6) lat = 6;
    case (mLive[2:0])
      3'b001: n = 4;
      3'b010: n = 8;
      3'b111: n = 64;
      default: n = 1;
    endcase
    qData.delete(); qWait.delete();
    for (int i = 0; i < n; i++) begin
      int a = beatAddr(base, i, mLive);
      if (i > 0 && lin && (a % 16) == 0) begin dq.push_back(prev); wf.push_back(1); end
      for (int k = 0; k < h; k++) begin dq.push_back(memFn(a[15:0])); wf.push_back(0); end
      prev = memFn(a[15:0]);
    end
    for (int k = 0; k < lat; k++) begin qData.push_back(lastData); qWait.push_back(0); end
    for (int j = 0; j < dq.size(); j++) begin
      qData.push_back(dq[j]);
      if (mLive[8]) qWait.push_back((j + 1 < dq.size()) ? wf[j+1] : 1'b0);
      else          qWait.push_back(wf[j]);
    end
    busyLeft = cont ? 1000000 : lat + dq.size();
  endtask

  task automatic modelEdge();
    bit busyBefore = (busyLeft > 0);
    bit startNow = !advN && !mLive[15];
    if (!advN) mBase = addrIn;
    if (!busyBefore && advN) mLive = mShadow;
    if (cfgWe && cfgData[6] && !cfgData[14] && cfgData[5:4] == 2'b00) mShadow = cfgData;
    if (startNow) buildBurst(mBase);
    else if (busyLeft > 0) busyLeft--;
    expW = 0;
    if (qData.size() > 0) begin
      lastData = qData.pop_front();
      expW = qWait.pop_front();
    end
    expD = mLive[15] ? memFn(mBase) : lastData;
  endtask

  task automatic compare();
    logic expLvl = (expW && !oeN) ? mLive[10] : !mLive[10];
    nChecks++;
    if (dataOut !== expD) begin
      nErr++; $display("FAIL %s: dataOut=%h expected %h", curTag, dataOut, expD);
    end
    nChecks++;
    if (waitOut !== expLvl) begin
      nErr++; $display("FAIL %s: waitOut=%b expected %b", curTag, waitOut, expLvl);
    end
  endtask

  task automatic cyc(bit a, logic [15:0] ad, bit we, logic [15:0] d);
    advN = a; addrIn = ad; cfgWe = we; cfgData = d;
    @(posedge clk);
    modelEdge();
    #5;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 16'h0, 0, 16'h0);
  endtask

  task automatic writeCfg(logic [15:0] w);
    cyc(1, 16'h0, 1, w);
    idle(1);
  endtask

  task automatic burst(logic [15:0] a, int n);
    cyc(0, a, 0, 16'h0);
    idle(n);
  endtask

  task automatic printSummary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    #(20 * 150000);
    nErr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    printSummary();
    $finish;
  end

  initial begin
    mShadow = 16'h9DCF; mLive = 16'h9DCF; lastData = '0; mBase = '0; busyLeft = 0;
    expD = memFn(16'h0); expW = 0;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    curTag = "R1"; compare(); idle(2);

    curTag = "R2";
    cyc(0, 16'h1234, 0, 0); idle(2); cyc(0, 16'hBEEF, 0, 0); cyc(0, 16'h0007, 0, 0); idle(1);

    curTag = "R6";
    writeCfg(mkCfg(0, 3, 1, 0, 1, 1, 0, 3'b001)); burst(16'h0106, 8);
    curTag = "R7";
    writeCfg(mkCfg(0, 5, 1, 1, 1, 0, 1, 3'b010)); burst(16'h2035, 24);
    curTag = "R4";
    writeCfg(mkCfg(0, 7, 1, 0, 0, 1, 0, 3'b001)); burst(16'h0040, 12);
    writeCfg(mkCfg(0, 0, 1, 0, 0, 1, 0, 3'b001)); burst(16'h0041, 8);
    curTag = "R12";
    writeCfg(mkCfg(0, 2, 1, 0, 1, 1, 1, 3'b000)); burst(16'h0010, 5);
    writeCfg(mkCfg(0, 3, 1, 0, 1, 1, 0, 3'b010)); burst(16'h00FE, 12);
    curTag = "R9";
    writeCfg(mkCfg(0, 4, 0, 0, 0, 1, 1, 3'b010)); burst(16'h003D, 16);
    curTag = "R10";
    writeCfg(mkCfg(0, 2, 1, 1, 1, 1, 1, 3'b010)); burst(16'h007C, 24);
    curTag = "R11";
    writeCfg(mkCfg(0, 2, 0, 0, 1, 1, 1, 3'b010)); oeN = 1'b1; burst(16'h00BE, 14);
    oeN = 1'b0;
    curTag = "R3";
    writeCfg(mkCfg(0, 3, 1, 1, 0, 1, 1, 3'b010));
    cyc(0, 16'h011C, 0, 0); idle(5);
    cyc(1, 0, 1, mkCfg(0, 2, 0, 0, 1, 1, 1, 3'b001)); idle(18);
    burst(16'h015E, 10);
    curTag = "R14";
    cyc(1, 0, 1, 16'h4040 | mkCfg(0, 5, 1, 1, 1, 0, 0, 3'b010)); idle(1);
    cyc(1, 0, 1, 16'h0010 | mkCfg(0, 6, 1, 0, 1, 0, 0, 3'b001)); idle(1);
    cyc(1, 0, 1, mkCfg(1, 3, 1, 0, 1, 1, 0, 3'b001) & 16'hFFBF); idle(1);
    burst(16'h0A3E, 10);
    curTag = "R13";
    writeCfg(mkCfg(0, 3, 1, 0, 0, 1, 1, 3'b010));
    cyc(0, 16'h0300, 0, 0); idle(4); burst(16'h050D, 16);
    curTag = "R2";
    writeCfg(mkCfg(1, 3, 1, 0, 1, 1, 0, 3'b001));
    cyc(0, 16'h4321, 0, 0); idle(2); cyc(0, 16'h0F0F, 0, 0); idle(1);
    curTag = "R8";
    writeCfg(mkCfg(0, 4, 1, 1, 1, 1, 0, 3'b111));
    burst(16'h00FA, 30);
    oeN = 1'b1; idle(3); oeN = 1'b0;
    burst(16'h01FE, 30);
    printSummary();
    $finish;
  end

endmodule